// File: doc/BRIEF.md
# Multi-mode Bit Synchroniser DPLL

This block recovers the receive bit timing from the zero crossings of a sliced, oversampled baseband signal. A phase counter, clocked by the reference clock, runs once per bit period; the nominal period is 128, 256, 512 or 1024 reference cycles, picked by a two-bit divider select. Each crossing strobe is compared with the point where a crossing is expected, half a bit away from the sampling point. The loop then pulls the counter towards the crossing by an amount that depends on the loop mode.

The mode is set by an acquire input and an active-low hold input. While acquire is high, every crossing snaps the phase fully into line. When acquire is released, a medium-bandwidth window of 30 bit periods follows, and after that a narrow-bandwidth mode applies. In both of these the loop corrects only on every second crossing and clamps the step. Pulling hold low with acquire low opens the loop, and the counter then free-wheels at the nominal rate. A quality flag grades every crossing by its distance from the expected time. Downstream logic samples received data on the rising edge of the recovered clock, marked by a one-cycle sample strobe.

Top module: `bitsync_dpll`

## Requirements
- R1: `smp_stb` is a one-cycle pulse every N reference cycles when no crossing arrives, with N = 128 for `div_sel`=00, 256 for 01, 512 for 10 and 1024 for 11. "Phase" below means the number of cycles since the last `smp_stb` (phase 0 is the strobe cycle).
- R2: `bit_clk` is high for phases 0 to N/2-1 and low for N/2 to N-1, so it rises in the cycle `smp_stb` is high. During and right after reset, `bit_clk`=1 and `quality`=0.
- R3: With `acq`=1, a crossing strobe sampled at phase p applies the full correction p-N/2 on every crossing, so the phase seen in the next cycle is N/2+1.
- R4: `hold_n` has no effect while `acq`=1: a crossing still receives the full correction of R3.
- R5: For 30 bit periods after `acq` falls, with `hold_n`=1, only every second crossing is corrected (the first crossing after acquire or hold gets none), and that correction is clamped to ±N/16.
- R6: Once the 30-bit window has passed, corrections follow the same pairing but are clamped to ±N/64.
- R7: With `hold_n`=0 and `acq`=0, crossings leave the phase untouched, the period stays N, and crossing pairing restarts from the first crossing once hold is released.
- R8: A crossing at phase p is good when |p-N/2| ≤ N/8 and bad otherwise. A bad crossing clears `quality` in the following cycle. The fourth consecutive good crossing sets it.
- R9: If a change of `div_sel` leaves the phase at or above the new N, the phase restarts at 0 in the next cycle, so `smp_stb` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 2 | Divider select, ratio 128 << div_sel |
| xing | input | 1 | One-cycle strobe marking a zero crossing |
| acq | input | 1 | Acquire control, wide-bandwidth loop while high |
| hold_n | input | 1 | Active-low hold, opens the loop when acq is low |
| bit_clk | output | 1 | Recovered bit clock, 50% duty |
| smp_stb | output | 1 | One-cycle pulse at the rising edge of bit_clk |
| quality | output | 1 | Crossing-quality flag, high after a run of good crossings |

## Verification
A crossing sampled at a rising edge changes the phase register at that edge. The bench drives crossings at a falling edge and counts falling edges from that point to the next strobe, which gives k = N - p + correction, so every correction is recovered arithmetically from one count. The quality flag is registered at the same edge as the crossing, so it is read at the first falling edge after the strobe and left undisturbed until the next crossing. A divider change that overruns the new range takes effect at the next edge, and the strobe is checked at the falling edge immediately after it. All sweeps use the smallest ratio except the period sweep, which covers all four select values.

// File: rtl/bsd_pkg.sv
// Shared definitions for the bit synchroniser DPLL.
// Assumes: nothing beyond IEEE 1800-2017.
package bsd_pkg;
    // Loop bandwidth mode chosen by the sequencer.
    typedef enum logic [1:0] {
        MD_ACQ  = 2'd0,
        MD_MED  = 2'd1,
        MD_NAR  = 2'd2,
        MD_HOLD = 2'd3
    } loop_mode_t;
endpackage

// File: rtl/bsd_mode_seq.sv
// Loop mode sequencer. Chooses acquire, medium, narrow or hold from the
// control inputs and a window counter of bit periods since acquire fell.
// Assumes: bit_tick pulses once per recovered bit; the window pauses in hold.
module bsd_mode_seq
    import bsd_pkg::*;
#(
    parameter int MED_BITS = 30,
    localparam int CW = $clog2(MED_BITS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acq,
    input  logic       hold_n,
    input  logic       bit_tick,
    output loop_mode_t mode
);
    logic [CW-1:0] win_q;
    logic          win_open;

    assign win_open = (win_q < CW'(MED_BITS));

    // Window counter: cleared by acquire, counts bits while the loop is closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= CW'(MED_BITS);
        end else if (acq) begin
            win_q <= '0;
        end else if (hold_n && bit_tick && win_open) begin
            win_q <= win_q + CW'(1);
        end
    end

    // Mode decode: acquire overrides hold; hold overrides the window.
    always_comb begin
        if (acq)           mode = MD_ACQ;
        else if (!hold_n)  mode = MD_HOLD;
        else if (win_open) mode = MD_MED;
        else               mode = MD_NAR;
    end
endmodule

// File: rtl/bsd_phase.sv
// Phase accumulator with bounded correction. Counts 0..N-1 per bit,
// N = 2**(MIN_LOG2+div_sel). Crossings are expected at N/2; the error is
// corrected in full in acquire and clamped on every second crossing in the
// medium and narrow modes.
// Assumes: xing is a single-cycle strobe in the reference clock domain.
module bsd_phase
    import bsd_pkg::*;
#(
    parameter int MIN_LOG2 = 7,
    localparam int PW = MIN_LOG2 + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           div_sel,
    input  logic                 xing,
    input  loop_mode_t           mode,
    output logic [PW-1:0]        phase_q,
    output logic [PW:0]          ratio,
    output logic signed [PW:0]   err,
    output logic signed [PW:0]   corr,
    output logic                 in_range,
    output logic                 bit_clk,
    output logic                 smp_stb
);
    logic [PW-1:0]          half;
    logic [PW-1:0]          lim;
    logic signed [PW:0]     lim_s;
    logic signed [PW:0]     clamped;
    logic signed [PW+1:0]   step;
    logic [PW-1:0]          phase_d;
    logic                   pair_q;
    logic                   paired_mode;

    assign ratio    = (PW+1)'(1) << (MIN_LOG2 + int'(div_sel));
    assign half     = PW'(ratio >> 1);
    assign in_range = ({1'b0, phase_q} < ratio);
    assign err      = $signed({1'b0, phase_q}) - $signed({1'b0, half});
    assign paired_mode = (mode == MD_MED) || (mode == MD_NAR);

    // Clamp limit per mode: N/16 in medium, N/64 in narrow.
    always_comb begin
        case (mode)
            MD_MED:  lim = PW'(ratio >> 4);
            MD_NAR:  lim = PW'(ratio >> 6);
            default: lim = '0;
        endcase
        lim_s = $signed({1'b0, lim});
    end

    // Saturate the phase error to the mode limit.
    always_comb begin
        if (err > lim_s)       clamped = lim_s;
        else if (err < -lim_s) clamped = -lim_s;
        else                   clamped = err;
    end

    // Correction actually applied this cycle.
    always_comb begin
        corr = '0;
        if (xing && in_range) begin
            if (mode == MD_ACQ)                corr = err;
            else if (paired_mode && pair_q)    corr = clamped;
        end
    end

    // Next phase: advance by one, subtract the correction, wrap at N.
    always_comb begin
        step = $signed({2'b00, phase_q}) + $signed((PW+2)'(1))
             - $signed({corr[PW], corr});
        if (!in_range)                              phase_d = '0;
        else if (step >= $signed({1'b0, ratio}))    phase_d = PW'(step - $signed({1'b0, ratio}));
        else                                        phase_d = PW'(step);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // Crossing-pair toggle: restarts outside the paired modes.
    always_ff @(posedge clk) begin
        if (!rst_n || !paired_mode) pair_q <= 1'b0;
        else if (xing && in_range)  pair_q <= ~pair_q;
    end

    assign bit_clk = in_range && (phase_q < half);
    assign smp_stb = (phase_q == '0);
endmodule

// File: rtl/bsd_quality.sv
// Crossing quality grader. A crossing is good within +/-N/8 of the expected
// time; a bad one clears the flag, GOOD_RUN good ones in a row set it.
// Assumes: valid pulses once per crossing that falls inside the bit range.
module bsd_quality #(
    parameter int PW       = 10,
    parameter int GOOD_RUN = 4,
    localparam int GW = $clog2(GOOD_RUN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic signed [PW:0]  err,
    input  logic [PW:0]         ratio,
    output logic                quality
);
    logic [GW-1:0]      run_q;
    logic signed [PW:0] win;
    logic               good;

    assign win  = $signed(ratio >> 3);
    assign good = (err <= win) && (err >= -win);

    // Run counter and flag update on each graded crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            quality <= 1'b0;
        end else if (valid) begin
            if (!good) begin
                run_q   <= '0;
                quality <= 1'b0;
            end else if (run_q == GW'(GOOD_RUN - 1)) begin
                quality <= 1'b1;
            end else begin
                run_q <= run_q + GW'(1);
            end
        end
    end
endmodule

// File: rtl/bitsync_dpll.sv
// Top of the multi-mode bit synchroniser DPLL: mode sequencer, phase
// accumulator and quality grader.
// Assumes: all inputs are synchronous to clk.
module bitsync_dpll
    import bsd_pkg::*;
#(
    parameter int MIN_LOG2 = 7,
    parameter int MED_BITS = 30,
    parameter int GOOD_RUN = 4,
    localparam int PW = MIN_LOG2 + 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       xing,
    input  logic       acq,
    input  logic       hold_n,
    output logic       bit_clk,
    output logic       smp_stb,
    output logic       quality
);
    loop_mode_t         mode;
    logic [PW-1:0]      phase_q;
    logic [PW:0]        ratio;
    logic signed [PW:0] err;
    logic signed [PW:0] corr;
    logic               in_range;

    bsd_mode_seq #(.MED_BITS(MED_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .acq(acq), .hold_n(hold_n),
        .bit_tick(smp_stb), .mode(mode)
    );

    bsd_phase #(.MIN_LOG2(MIN_LOG2)) u_phase (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .xing(xing),
        .mode(mode), .phase_q(phase_q), .ratio(ratio), .err(err),
        .corr(corr), .in_range(in_range), .bit_clk(bit_clk),
        .smp_stb(smp_stb)
    );

    bsd_quality #(.PW(PW), .GOOD_RUN(GOOD_RUN)) u_qual (
        .clk(clk), .rst_n(rst_n), .valid(xing && in_range), .err(err),
        .ratio(ratio), .quality(quality)
    );
endmodule

// File: rtl/bitsync_dpll_chk.sv
// Assertion checker for bitsync_dpll, bound into every instance.
// Assumes: signal names match the top module's internal nets.
module bitsync_dpll_chk
    import bsd_pkg::*;
#(
    parameter int PW = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acq,
    input logic               hold_n,
    input logic               xing,
    input logic               bit_clk,
    input logic               smp_stb,
    input logic               quality,
    input loop_mode_t         mode,
    input logic [PW-1:0]      phase_q,
    input logic [PW:0]        ratio,
    input logic signed [PW:0] err,
    input logic signed [PW:0] corr
);
    logic signed [PW:0] lim_med, lim_nar, lim_q;
    assign lim_med = $signed({1'b0, ratio >> 4});
    assign lim_nar = $signed({1'b0, ratio >> 6});
    assign lim_q   = $signed({1'b0, ratio >> 3});

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb);                                              // R1
    AST_CLK_RISE_AT_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_clk) |-> smp_stb);                                        // R2
    AST_ACQ_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (acq && xing && ({1'b0, phase_q} < ratio))
        |=> ({1'b0, phase_q} == ($past(ratio) >> 1) + (PW+1)'(1)));        // R3
    AST_MED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_MED) |-> (corr <= lim_med && corr >= -lim_med));        // R5
    AST_NAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_NAR) |-> (corr <= lim_nar && corr >= -lim_nar));        // R6
    AST_HOLD_FREEWHEEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq && !hold_n && ({1'b0, phase_q} + (PW+1)'(1) < ratio))
        |=> (phase_q == $past(phase_q) + PW'(1)));                          // R7
    AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (xing && ({1'b0, phase_q} < ratio) && (err > lim_q || err < -lim_q))
        |=> !quality);                                                      // R8
endmodule

bind bitsync_dpll bitsync_dpll_chk #(.PW(PW)) u_chk (.*);

// File: tb/tb_bitsync_dpll.sv
module tb_bitsync_dpll;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       xing = 1'b0;
    logic       acq = 1'b0;
    logic       hold_n = 1'b1;
    logic       bit_clk, smp_stb, quality;
    int         total = 0;
    int         bad = 0;

    bitsync_dpll dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .xing(xing),
        .acq(acq), .hold_n(hold_n), .bit_clk(bit_clk), .smp_stb(smp_stb),
        .quality(quality)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a crossing at phase p; return the correction seen at the ports.
    task automatic xing_at(input int p, input int n, output int corr);
        int k;
        @(negedge clk);
        while (!smp_stb) @(negedge clk);
        repeat (p) @(negedge clk);
        xing = 1'b1;
        @(negedge clk);
        xing = 1'b0;
        k = 1;
        while (!smp_stb) begin
            @(negedge clk);
            k++;
        end
        corr = k - n + p;
    endtask

    // Measure one full bit period and the bit_clk high time within it.
    task automatic measure(output int per, output int hi);
        @(negedge clk);
        while (!smp_stb) @(negedge clk);
        per = 0;
        hi = 0;
        do begin
            hi += bit_clk ? 1 : 0;
            per++;
            @(negedge clk);
        end while (!smp_stb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c, per, hi;
        repeat (3) @(negedge clk);
        check("R2 reset quality", int'(quality), 0);
        check("R2 reset bit_clk", int'(bit_clk), 1);

        // R1, R2: period and duty over all divider selections.
        for (int s = 0; s < 4; s++) begin
            rst_n = 1'b0;
            div_sel = 2'(s);
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            measure(per, hi);
            check("R1 period", per, 128 << s);
            check("R2 high time", hi, 64 << s);
        end
        rst_n = 1'b0;
        div_sel = 2'b00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R3: full correction across every crossing phase in acquire.
        acq = 1'b1;
        for (int p = 0; p < 128; p++) begin
            xing_at(p, 128, c);
            check("R3 acquire correction", c, p - 64);
        end
        check("R8 bad crossing clears", int'(quality), 0);

        // R8: good-run boundary at +N/8, bad at -N/8-1.
        for (int i = 0; i < 4; i++) begin
            xing_at(80, 128, c);
            check("R8 run length", int'(quality), (i == 3) ? 1 : 0);
        end
        xing_at(47, 128, c);
        check("R8 bad at -17", int'(quality), 0);
        for (int i = 0; i < 4; i++) xing_at(48, 128, c);
        check("R8 good at -16", int'(quality), 1);

        // R4: hold ignored while acquiring.
        hold_n = 1'b0;
        xing_at(30, 128, c);
        check("R4 hold ignored", c, -34);
        hold_n = 1'b1;

        // R5: medium window after acquire falls.
        acq = 1'b0;
        xing_at(100, 128, c); check("R5 first of pair", c, 0);
        xing_at(100, 128, c); check("R5 clamp +8", c, 8);
        xing_at(20, 128, c);  check("R5 first of pair", c, 0);
        xing_at(20, 128, c);  check("R5 clamp -8", c, -8);
        xing_at(70, 128, c);  check("R5 first of pair", c, 0);
        xing_at(70, 128, c);  check("R5 small error", c, 6);

        // R6: narrow mode after the window.
        repeat (40) begin
            @(negedge clk);
            while (!smp_stb) @(negedge clk);
        end
        xing_at(100, 128, c); check("R6 first of pair", c, 0);
        xing_at(100, 128, c); check("R6 clamp +2", c, 2);
        xing_at(60, 128, c);  check("R6 first of pair", c, 0);
        xing_at(60, 128, c);  check("R6 clamp -2", c, -2);

        // R7: hold opens the loop and keeps the period.
        hold_n = 1'b0;
        xing_at(10, 128, c);  check("R7 hold no correction", c, 0);
        xing_at(120, 128, c); check("R7 hold no correction", c, 0);
        xing_at(10, 128, c);  check("R7 hold no correction", c, 0);
        measure(per, hi);
        check("R7 hold period", per, 128);
        hold_n = 1'b1;
        xing_at(100, 128, c); check("R7 pairing restarts", c, 0);
        xing_at(100, 128, c); check("R7 second corrected", c, 2);

        // R9: divider change that overruns the new range.
        div_sel = 2'b11;
        @(negedge clk);
        while (!smp_stb) @(negedge clk);
        repeat (500) @(negedge clk);
        div_sel = 2'b00;
        @(negedge clk);
        check("R9 restart strobe", int'(smp_stb), 1);
        measure(per, hi);
        check("R9 new period", per, 128);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule